// File: doc/BRIEF.md
# Hierarchical Vertical-Crosswise Multiplier

This block is a purely combinational unsigned multiplier. A 2x2 cell, which forms every partial bit at once from the straight and crossed bit pairs, is the base of the structure. Each level of the hierarchy builds a unit of double width from four half-width units, one for each pairing of low and high operand halves. Three explicitly aligned ripple-carry adders, each as wide as the unit, then merge the four quadrant sub-products. With the default width of 8, the top uses four 4x4 units, and each 4x4 unit uses four 2x2 cells.

An active-high idle input stands for a power-gated state at the logic level. While it is set, the result is held at zero whatever the operands are. When it is released, the true product is on the output again at once. The block has no clock and no storage. A surrounding pipeline registers the result if it needs a registered output.

Top module: `vx_mult`

## Requirements
- R1: With `sleep` at 0, `product` equals the unsigned product `a_op * b_op` for every pair of 8-bit operands.
- R2: The 2x2 base cell gives the exact 4-bit product of two 2-bit values. Operands below 4 therefore give products from 0 to 9.
- R3: The result equals the sum of the four quadrant products `aL*bL + 16*(aL*bH + aH*bL) + 256*aH*bH`, where `aL`/`aH` are bits [3:0]/[7:4]. An operand with only one nonzero nibble gives that nibble's product shifted by 4 bits.
- R4: With `sleep` at 0, `product[3:0]` equals the low nibble of `aL*bL`.
- R5: The carry out of the cross-term adder and the carry out of the middle adder are never both set. Their OR enters bit 4 of the last adder's second input, so a case such as 255*47 = 11985 comes out right.
- R6: The last adder never produces a carry out. The largest product, 255*255 = 65025, fits in 16 bits.
- R7: With `sleep` at 1, `product` is 0 for any operands.
- R8: After `sleep` falls to 0, `product` shows the product of the current operands in the same evaluation, with no settling cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 8 | Unsigned multiplicand |
| b_op | input | 8 | Unsigned multiplier |
| sleep | input | 1 | 1 = idle, output forced to zero; 0 = normal operation |
| product | output | 16 | Unsigned product, or zero when idle |

## Verification
Every result of this block is due in the same cycle as its stimulus, because there is no register between operands and product. The bench therefore changes operands and `sleep` just after a falling clock edge and reads `product` two nanoseconds later, still inside the same half period. All 65536 operand pairs run with `sleep` low. Idle patterns follow, and then a release of `sleep` that is read within that same half period.

// File: rtl/vx_pkg.sv
package vx_pkg;

  // one-bit full adder: returns {carry, sum}
  function automatic logic [1:0] fa(input logic x, input logic y, input logic ci);
    logic s;
    logic c;
    s = x ^ y ^ ci;
    c = (x & y) | (ci & (x ^ y));
    return {c, s};
  endfunction

  // 2x2 vertical-crosswise product
  function automatic logic [3:0] vc2(input logic [1:0] x, input logic [1:0] y);
    logic t_lo;
    logic t_hi;
    logic k;
    logic h;
    t_lo = x[1] & y[0];
    t_hi = x[0] & y[1];
    k    = t_lo & t_hi;
    h    = x[1] & y[1];
    return {h & k, h ^ k, t_lo ^ t_hi, x[0] & y[0]};
  endfunction

endpackage

// File: rtl/vx_rca.sv
module vx_rca #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign {c[i+1], s[i]} = vx_pkg::fa(x[i], y[i], c[i]);
  end
  assign co = c[W];
endmodule

// File: rtl/vx_cell2.sv
module vx_cell2 (
  input  logic [1:0] x,
  input  logic [1:0] y,
  output logic [3:0] p
);
  assign p = vx_pkg::vc2(x, y);
endmodule

// File: rtl/vx_node.sv
module vx_node #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod,
  output logic           wrap
);
  localparam int H = W / 2;

  if (W == 2) begin : g_leaf
    vx_cell2 u_cell (.x(a), .y(b), .p(prod));
    assign wrap = 1'b0;
  end else begin : g_split
    logic [W-1:0] q_ll, q_lh, q_hl, q_hh;
    logic [3:0]   sub_wrap;
    logic [W-1:0] s_cross, s_mid, s_top;
    logic         c_cross, c_mid, c_top;

    vx_node #(.W(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .prod(q_ll), .wrap(sub_wrap[0]));
    vx_node #(.W(H)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .prod(q_lh), .wrap(sub_wrap[1]));
    vx_node #(.W(H)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .prod(q_hl), .wrap(sub_wrap[2]));
    vx_node #(.W(H)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .prod(q_hh), .wrap(sub_wrap[3]));

    vx_rca #(.W(W)) u_cross (.x(q_lh), .y(q_hl), .s(s_cross), .co(c_cross));
    vx_rca #(.W(W)) u_mid (.x(s_cross), .y({{H{1'b0}}, q_ll[W-1:H]}),
                           .s(s_mid), .co(c_mid));
    vx_rca #(.W(W)) u_top (.x(q_hh),
                           .y({{(H-1){1'b0}}, c_cross | c_mid, s_mid[W-1:H]}),
                           .s(s_top), .co(c_top));

    assign prod = {s_top, s_mid[H-1:0], q_ll[H-1:0]};
    assign wrap = c_top | (c_cross & c_mid) | (|sub_wrap);
  end
endmodule

// File: rtl/vx_mult.sv
module vx_mult #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   a_op,
  input  logic [WIDTH-1:0]   b_op,
  input  logic               sleep,
  output logic [2*WIDTH-1:0] product
);
  localparam int H = WIDTH / 2;

  logic [WIDTH-1:0]   q_ll, q_lh, q_hl, q_hh;
  logic [3:0]         sub_wrap;
  logic [WIDTH-1:0]   s_cross, s_mid, s_top;
  logic               c_cross, c_mid, c_top;
  logic               wrap_any;
  logic [2*WIDTH-1:0] raw;

  vx_node #(.W(H)) u_ll (.a(a_op[H-1:0]),     .b(b_op[H-1:0]),     .prod(q_ll), .wrap(sub_wrap[0]));
  vx_node #(.W(H)) u_lh (.a(a_op[H-1:0]),     .b(b_op[WIDTH-1:H]), .prod(q_lh), .wrap(sub_wrap[1]));
  vx_node #(.W(H)) u_hl (.a(a_op[WIDTH-1:H]), .b(b_op[H-1:0]),     .prod(q_hl), .wrap(sub_wrap[2]));
  vx_node #(.W(H)) u_hh (.a(a_op[WIDTH-1:H]), .b(b_op[WIDTH-1:H]), .prod(q_hh), .wrap(sub_wrap[3]));

  // cross terms, then the low sub-product's upper half, then the high term
  vx_rca #(.W(WIDTH)) u_cross (.x(q_lh), .y(q_hl), .s(s_cross), .co(c_cross));
  vx_rca #(.W(WIDTH)) u_mid (.x(s_cross), .y({{H{1'b0}}, q_ll[WIDTH-1:H]}),
                             .s(s_mid), .co(c_mid));
  vx_rca #(.W(WIDTH)) u_top (.x(q_hh),
                             .y({{(H-1){1'b0}}, c_cross | c_mid, s_mid[WIDTH-1:H]}),
                             .s(s_top), .co(c_top));

  assign raw      = {s_top, s_mid[H-1:0], q_ll[H-1:0]};
  assign wrap_any = c_top | (|sub_wrap);
  assign product  = sleep ? '0 : raw;
endmodule

// File: rtl/vx_mult_chk.sv
module vx_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0]   a_op,
  input logic [WIDTH-1:0]   b_op,
  input logic               sleep,
  input logic [2*WIDTH-1:0] product,
  input logic [WIDTH-1:0]   q_ll,
  input logic               c_cross,
  input logic               c_mid,
  input logic               wrap_any
);
  localparam int H = WIDTH / 2;
  logic [2*WIDTH-1:0] ref_p;
  assign ref_p = {{WIDTH{1'b0}}, a_op} * {{WIDTH{1'b0}}, b_op};

  always_comb begin
    p_exact_r1: assert (sleep || product == ref_p);
    p_low_bits_r4: assert (sleep || product[H-1:0] == q_ll[H-1:0]);
    p_carry_excl_r5: assert (!(c_cross && c_mid));
    p_no_wrap_r6: assert (!wrap_any);
    p_idle_zero_r7: assert (!sleep || product == '0);
  end
endmodule

bind vx_mult vx_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .a_op(a_op), .b_op(b_op), .sleep(sleep), .product(product),
  .q_ll(q_ll), .c_cross(c_cross), .c_mid(c_mid), .wrap_any(wrap_any)
);

// File: tb/vx_mult_test.sv
`timescale 1ns/1ps
module vx_mult_test;
  logic        clk = 1'b0;
  logic [7:0]  a_op = '0;
  logic [7:0]  b_op = '0;
  logic        sleep = 1'b1;
  logic [15:0] product;
  int          errors = 0;
  int          checks = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  vx_mult uut (.a_op(a_op), .b_op(b_op), .sleep(sleep), .product(product));

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: act=%0d exp=%0d cycles", cycles, 150000);
      report();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: act=%0d exp=%0d (a=%0d b=%0d sleep=%0d)",
               req, act, exp, a_op, b_op, sleep);
    end
  endtask

  task automatic apply(input int a, input int b, input bit slp);
    @(negedge clk);
    a_op  = 8'(a);
    b_op  = 8'(b);
    sleep = slp;
    #2;
  endtask

  initial begin
    // reset-like idle state: sleep held at start
    apply(0, 0, 1'b1);
    check("R7 idle at start", int'(product), 0);

    // exhaustive sweep awake
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        apply(a, b, 1'b0);
        check("R1 product", int'(product), a * b);
        check("R4 low nibble", int'(product[3:0]), ((a % 16) * (b % 16)) % 16);
        if (a < 4 && b < 4) check("R2 base cell", int'(product), a * b);
        if ((a % 16 == 0) && (b < 16)) check("R3 high nibble only", int'(product), ((a / 16) * b) * 16);
      end
    end

    // carry merge case and largest product
    apply(255, 47, 1'b0);
    check("R5 carry merge", int'(product), 11985);
    apply(47, 255, 1'b0);
    check("R5 carry merge swapped", int'(product), 11985);
    apply(255, 255, 1'b0);
    check("R6 largest", int'(product), 65025);

    // idle patterns
    for (int i = 0; i < 256; i++) begin
      apply(i, 255 - i, 1'b1);
      check("R7 idle", int'(product), 0);
    end
    apply(255, 255, 1'b1);
    check("R7 idle max", int'(product), 0);

    // release from idle: result in the same evaluation
    @(negedge clk);
    a_op  = 8'd201;
    b_op  = 8'd77;
    #1;
    check("R7 idle before release", int'(product), 0);
    sleep = 1'b0;
    #1;
    check("R8 release", int'(product), 201 * 77);
    apply(13, 250, 1'b0);
    check("R8 follow", int'(product), 13 * 250);

    report();
  end
endmodule